// File: doc/BRIEF.md
# Dual Timer/Counter with Gating and Four Count Modes

This block holds two timer/counter channels that share one machine-cycle prescaler. Each channel keeps a 16-bit count as a high and a low byte. A 4-bit mode field controls each channel: a gate-enable bit, a source select and two structure bits. Software writes each count byte, the shared mode byte, the run bits and the overflow flags through a small byte-wide write port.

A channel counts when its run bit is set. If its gate-enable bit is also set, the external gate pin must be high as well. The source is either the machine-cycle tick, which comes once every `CYC_DIV` clocks, or a falling edge on the channel's count pin. The pin is sampled on each tick.

There are four count structures:
- a 13-bit count;
- a 16-bit count;
- an 8-bit count that reloads on overflow;
- a split arrangement in which channel 0 becomes two independent 8-bit counters.

Each overflow raises a one-clock pulse and sets a sticky flag for an interrupt controller. The interrupt controller clears the flag with `vec_ack` when it takes the vector.

Top module: `tmr_pair`

## Requirements
- R1: After reset, all count bytes, the mode byte, the run bits, the flags and the pulses are zero.
- R2: In timer source (select bit 0), a running channel advances by exactly one per `CYC_DIV` clocks (12 by default), so a run window of 12·K clocks adds exactly K. With both run bits 0 and no write, no count byte changes.
- R3: Structure bits 01 give a 16-bit count {high, low}. A step from 0xFFFF wraps to 0x0000, sets the channel's flag and raises its `ovf_pulse` for one clock.
- R4: Structure bits 00 give a 13-bit count. The high byte holds bits 12..5 and the low byte bits 4..0 hold bits 4..0. The low byte bits 7..5 are never changed by counting. Overflow is the step from 0x1FFF to 0.
- R5: Structure bits 10 count the low byte only. A step from 0xFF loads the low byte from the high byte and sets the flag. The high byte is not changed by counting.
- R6: When channel 0's structure bits are 11, several things change:
  - Channel 0's low byte counts 8 bits under channel 0's own run, gate and source, and sets flag 0.
  - Channel 0's high byte counts ticks under run bit 1 alone and sets flag 1.
  - Channel 1's own overflow no longer reaches flag 1.
  - A channel whose structure bits are 11 does not count on its own.
- R7: With the gate-enable bit at 1, a channel counts only while its `gate_pin` is high. With it at 0, the gate pin has no effect.
- R8: With the source select bit at 1, the channel advances once for each tick on which the previous tick's sample of `cnt_pin` was 1 and this tick's sample is 0.
- R9: A flag is cleared by the matching `vec_ack` bit or set to any value by a write to address 6 (bits 1:0 map to flags 1:0). An overflow in the same clock takes precedence and leaves the flag set.
- R10: Write addresses are:
  - 0: channel 0 low byte; 1: channel 0 high byte;
  - 2: channel 1 low byte; 3: channel 1 high byte;
  - 4: mode byte (channel 1 in bits 7..4, channel 0 in bits 3..0; in each nibble gate-enable is bit 3, source select bit 2, structure bits 1..0);
  - 5: run bits (bit 0 for channel 0, bit 1 for channel 1).

  A byte write takes precedence over counting in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data |
| vec_ack | input | 2 | Per-channel flag clear when its vector is taken |
| cnt_pin | input | 2 | External count pins, one per channel |
| gate_pin | input | 2 | External gate pins, one per channel |
| lo0_q | output | 8 | Channel 0 low byte |
| hi0_q | output | 8 | Channel 0 high byte |
| lo1_q | output | 8 | Channel 1 low byte |
| hi1_q | output | 8 | Channel 1 high byte |
| mode_q | output | 8 | Mode byte |
| run_q | output | 2 | Run bits |
| ovf_flag | output | 2 | Sticky overflow flags |
| ovf_pulse | output | 2 | One-clock overflow pulses |

## Verification
The bench sweeps run windows across each wrap point, so that a count off by one tick or a wrap detected one step early or late moves both the final byte and the flag.

In the 13-bit sweep the upper low-byte bits are preset to a non-zero pattern. A carry taken from bit 7 instead of bit 4 would corrupt that pattern and land in the wrong high-byte value.

The reload sweep catches a design that reloads from the wrong byte or lets the reload value drift. The split test catches a high byte that follows channel 0's run bit, raises the wrong flag, or lets channel 1 keep counting.

Pin-driven counting at the fastest legal toggle rate exposes an edge detector that misses alternate samples or counts level instead of transitions. Pulses sent while the channel is stopped expose a detector that counts them anyway.

// File: rtl/tmr_pair.sv
`timescale 1ns/1ps
module tmr_pair #(
  parameter int CYC_DIV = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] vec_ack,
  input  logic [1:0] cnt_pin,
  input  logic [1:0] gate_pin,
  output logic [7:0] lo0_q,
  output logic [7:0] hi0_q,
  output logic [7:0] lo1_q,
  output logic [7:0] hi1_q,
  output logic [7:0] mode_q,
  output logic [1:0] run_q,
  output logic [1:0] ovf_flag,
  output logic [1:0] ovf_pulse
);
  localparam int PW = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
  localparam logic [PW-1:0] PMAX = PW'(CYC_DIV - 1);

  logic [PW-1:0]   pre;
  logic            tick;
  logic [1:0][7:0] lo, hi, lo_n, hi_n;
  logic [1:0][1:0] md;
  logic [1:0]      smp, old, fall, en, inc, ov, set;
  logic            split, inc_h, ov_h;
  logic [13:0]     s13;
  logic [16:0]     s16;
  logic [8:0]      s8;

  assign tick  = (pre == PMAX);
  assign md[0] = mode_q[1:0];
  assign md[1] = mode_q[5:4];
  assign fall  = old & ~smp;
  assign split = (md[0] == 2'b11);
  assign inc_h = tick & split & run_q[1];

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      en[c]  = run_q[c] & (~mode_q[4*c+3] | gate_pin[c]);
      inc[c] = tick & en[c] & (mode_q[4*c+2] ? fall[c] : 1'b1);
    end
  end

  always_comb begin
    lo_n = lo;
    hi_n = hi;
    ov   = '0;
    ov_h = 1'b0;
    s13  = '0;
    s16  = '0;
    s8   = '0;
    for (int c = 0; c < 2; c++) begin
      if (inc[c]) begin
        case (md[c])
          2'b00: begin
            s13 = {1'b0, hi[c], lo[c][4:0]} + 14'd1;
            hi_n[c]      = s13[12:5];
            lo_n[c][4:0] = s13[4:0];
            ov[c]        = s13[13];
          end
          2'b01: begin
            s16 = {1'b0, hi[c], lo[c]} + 17'd1;
            {hi_n[c], lo_n[c]} = s16[15:0];
            ov[c] = s16[16];
          end
          2'b10: begin
            if (lo[c] == 8'hFF) begin
              lo_n[c] = hi[c];
              ov[c]   = 1'b1;
            end else begin
              lo_n[c] = lo[c] + 8'd1;
            end
          end
          default: begin
            if (c == 0) begin
              s8 = {1'b0, lo[c]} + 9'd1;
              lo_n[c] = s8[7:0];
              ov[c]   = s8[8];
            end
          end
        endcase
      end
    end
    if (inc_h) {ov_h, hi_n[0]} = {1'b0, hi[0]} + 9'd1;
  end

  assign set[0] = ov[0];
  assign set[1] = split ? ov_h : ov[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre       <= '0;
      lo        <= '0;
      hi        <= '0;
      mode_q    <= '0;
      run_q     <= '0;
      ovf_flag  <= '0;
      ovf_pulse <= '0;
      smp       <= '0;
      old       <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) begin
        smp <= cnt_pin;
        old <= smp;
      end
      lo <= lo_n;
      hi <= hi_n;
      if (wr_en) begin
        case (wr_addr)
          3'd0: lo[0]  <= wr_data;
          3'd1: hi[0]  <= wr_data;
          3'd2: lo[1]  <= wr_data;
          3'd3: hi[1]  <= wr_data;
          3'd4: mode_q <= wr_data;
          3'd5: run_q  <= wr_data[1:0];
          default: ;
        endcase
      end
      ovf_flag  <= ((wr_en && wr_addr == 3'd6) ? wr_data[1:0] : (ovf_flag & ~vec_ack)) | set;
      ovf_pulse <= set;
    end
  end

  assign lo0_q = lo[0];
  assign hi0_q = hi[0];
  assign lo1_q = lo[1];
  assign hi1_q = hi[1];
endmodule

// File: rtl/tmr_pair_chk.sv
`timescale 1ns/1ps
module tmr_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] lo0_q,
  input logic [7:0] hi0_q,
  input logic [7:0] lo1_q,
  input logic [7:0] hi1_q,
  input logic [7:0] mode_q,
  input logic [1:0] run_q,
  input logic [1:0] ovf_flag,
  input logic [1:0] ovf_pulse
);
  a_r2_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && run_q == 2'b00) |=> ($stable(lo0_q) && $stable(hi0_q) && $stable(lo1_q) && $stable(hi1_q)));

  a_r3_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse != 2'b00) |-> ((ovf_flag & ovf_pulse) == ovf_pulse));

  a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse[0] |=> !ovf_pulse[0]);

  a_r2_pulse_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse[0] |-> $past(run_q[0]));

  a_r4_upper_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b00 && !(wr_en && wr_addr == 3'd0)) |=> $stable(lo0_q[7:5]));

  a_r5_reload_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b10 && !(wr_en && wr_addr == 3'd1)) |=> $stable(hi0_q));

  a_r6_ch1_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[5:4] == 2'b11 && !(wr_en && (wr_addr == 3'd2 || wr_addr == 3'd3)))
      |=> ($stable(lo1_q) && $stable(hi1_q)));
endmodule

bind tmr_pair tmr_pair_chk u_chk (.*);

// File: tb/test_tmr_pair.sv
`timescale 1ns/1ps
module test_tmr_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] vec_ack = '0;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic [7:0] lo0_q, hi0_q, lo1_q, hi1_q, mode_q;
  logic [1:0] run_q, ovf_flag, ovf_pulse;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  tmr_pair i_tmr_pair (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_for(input logic [1:0] r, input int k);
    wr(3'd5, {6'd0, r});
    repeat (12*k - 1) @(negedge clk);
    wr(3'd5, 8'd0);
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 lo0", lo0_q, 0); chk("R1 hi0", hi0_q, 0);
    chk("R1 lo1", lo1_q, 0); chk("R1 hi1", hi1_q, 0);
    chk("R1 mode", mode_q, 0); chk("R1 run", run_q, 0);
    chk("R1 flag", ovf_flag, 0); chk("R1 pulse", ovf_pulse, 0);

    // R3 / R2 / R10: 16-bit on both channels, sweep across wrap on ch1
    wr(3'd4, 8'h11);
    chk("R10 mode write", mode_q, 8'h11);
    for (int k = 10; k <= 22; k++) begin
      wr(3'd6, 8'd0);
      wr(3'd0, 8'h34); wr(3'd1, 8'h12);
      wr(3'd2, 8'hF0); wr(3'd3, 8'hFF);
      run_for(2'b11, k);
      chk("R2 ch0 tick count", {hi0_q, lo0_q}, 16'h1234 + k);
      chk("R3 ch1 wrap", {hi1_q, lo1_q}, (16'hFFF0 + k) & 16'hFFFF);
      chk("R3 ch1 flag", ovf_flag[1], (k >= 16) ? 1 : 0);
      chk("R3 ch0 no flag", ovf_flag[0], 0);
    end

    // R2 stopped: nothing moves
    repeat (40) @(negedge clk);
    chk("R2 stopped", {hi0_q, lo0_q}, 16'h1234 + 22);

    // R9 flag clear paths
    wr(3'd6, 8'd3);
    chk("R9 flag write", ovf_flag, 3);
    vec_ack = 2'b01; @(negedge clk); vec_ack = 2'b00;
    chk("R9 ack clears one", ovf_flag, 2);
    wr(3'd6, 8'd0);
    chk("R9 flag write zero", ovf_flag, 0);

    // R4 13-bit sweep on ch0
    wr(3'd4, 8'h00);
    for (int k = 1; k <= 12; k++) begin
      int v;
      wr(3'd6, 8'd0);
      wr(3'd0, 8'hBA); wr(3'd1, 8'hFF);
      run_for(2'b01, k);
      v = (16'h1FFA + k) % 8192;
      chk("R4 low byte", lo0_q, 8'hA0 | (v & 31));
      chk("R4 high byte", hi0_q, v >> 5);
      chk("R4 flag", ovf_flag[0], (k >= 6) ? 1 : 0);
    end

    // R5 reload sweep on ch0
    wr(3'd4, 8'h02);
    for (int k = 1; k <= 24; k++) begin
      int v, f;
      wr(3'd6, 8'd0);
      wr(3'd0, 8'hFC); wr(3'd1, 8'hF8);
      run_for(2'b01, k);
      v = 8'hFC; f = 0;
      for (int i = 0; i < k; i++) begin
        if (v == 8'hFF) begin v = 8'hF8; f = 1; end
        else v = v + 1;
      end
      chk("R5 low byte", lo0_q, v);
      chk("R5 reload kept", hi0_q, 8'hF8);
      chk("R5 flag", ovf_flag[0], f);
    end

    // R7 gate
    wr(3'd4, 8'h09);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    gate_pin = 2'b00;
    run_for(2'b01, 10);
    chk("R7 gate low blocks", {hi0_q, lo0_q}, 0);
    gate_pin = 2'b01;
    run_for(2'b01, 10);
    chk("R7 gate high counts", {hi0_q, lo0_q}, 10);
    wr(3'd4, 8'h01);
    gate_pin = 2'b00;
    run_for(2'b01, 5);
    chk("R7 gate ignored when disabled", {hi0_q, lo0_q}, 15);

    // R8 external falling edges
    wr(3'd4, 8'h05);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    cnt_pin = 2'b11;
    repeat (36) @(negedge clk);
    for (int n = 0; n < 3; n++) begin
      cnt_pin[0] = 1'b0; repeat (12) @(negedge clk);
      cnt_pin[0] = 1'b1; repeat (12) @(negedge clk);
    end
    chk("R8 no count while stopped", {hi0_q, lo0_q}, 0);
    wr(3'd5, 8'd1);
    for (int n = 0; n < 7; n++) begin
      cnt_pin[0] = 1'b0; repeat (12) @(negedge clk);
      cnt_pin[0] = 1'b1; repeat (12) @(negedge clk);
    end
    for (int n = 0; n < 4; n++) begin
      cnt_pin[0] = 1'b0; repeat (36) @(negedge clk);
      cnt_pin[0] = 1'b1; repeat (36) @(negedge clk);
    end
    repeat (36) @(negedge clk);
    wr(3'd5, 8'd0);
    chk("R8 edge count", {hi0_q, lo0_q}, 11);

    // R6 split
    wr(3'd6, 8'd0);
    wr(3'd4, 8'h33);
    wr(3'd0, 8'hF0); wr(3'd1, 8'hFE);
    wr(3'd2, 8'h55); wr(3'd3, 8'h66);
    run_for(2'b11, 20);
    chk("R6 low byte", lo0_q, 8'h04);
    chk("R6 high byte", hi0_q, 8'h12);
    chk("R6 ch1 held", {hi1_q, lo1_q}, 16'h6655);
    chk("R6 flags", ovf_flag, 3);
    wr(3'd6, 8'd0);
    run_for(2'b10, 5);
    chk("R6 high under run1", hi0_q, 8'h17);
    chk("R6 low stays", lo0_q, 8'h04);
    wr(3'd4, 8'h13);
    wr(3'd2, 8'hF0); wr(3'd3, 8'hFF);
    run_for(2'b10, 20);
    chk("R6 ch1 overflow masked", ovf_flag[1], 0);
    chk("R6 ch1 counts", {hi1_q, lo1_q}, 16'h0004);
    chk("R6 high byte again", hi0_q, 8'h2B);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule